// File: doc/BRIEF.md
# Two-wire serial EEPROM slave with a write-lockable lower half

This block is a synthesizable slave for a shared two-wire serial bus (I2C style, SCL and SDA). It behaves as a 256-byte serial EEPROM. The host can store one byte or a burst of up to 16 bytes in a single write transaction. It can read from a chosen address, from the current address, or as a continuous stream. The slave drives SDA open-drain: the output `sdaOe` pulls the line low when it is set. Both bus lines are synchronised to the system clock, and every bus event is found by oversampling.

Three strap pins form the low bits of the slave address, so eight copies can share one bus. A write-inhibit pin blocks all changes to the array. A separate command, sent under its own device code, locks the lower 128 bytes against writes. The lock can never be undone, and the upper 128 bytes remain writable.

After each write or lock command the block runs a programming interval of fixed length. During that interval it declines its address, so the host polls with address bytes until it gets an ACK.

Top module: `lockhalf_eeprom`

## Requirements
- R1: After reset every array byte reads FFh, the lock is clear, the current address is 00h, and `sdaOe` is 0.
- R2: A device byte is acknowledged only when its upper nibble is 1010b and bits 3:1 equal `strapAddr[2:0]`. Bit 0 is the direction, with 1 for read. A device byte with other strap bits gets NACK.
- R3: A byte write (device byte with bit 0 = 0, word address, data, STOP) acknowledges each byte and stores the data at that address.
- R4: In a multi-byte write, the address advances only in its low 4 bits and wraps inside the 16-byte page. A 17th byte overwrites the first byte written in that transaction.
- R5: A random read (dummy write of the address, repeated START, read device byte) returns the byte at that address. A read without a dummy write continues at the current address. The address advances by one after every byte read.
- R6: A sequential read continues while the master ACKs each byte, wraps from FFh to 00h, and ends when the master NACKs.
- R7: While `writeCtrl` is 1, data bytes of a write get NACK and the array is unchanged.
- R8: The lock command is a device byte 0110b + strap bits + bit 0 = 0, followed by one address byte and one data byte (both values ignored), then STOP. It sets the lock. After that, data written to 00h–7Fh gets NACK and is not stored, while 80h–FFh stays writable.
- R9: The lock can never be cleared. Once it is set, the lock device byte gets NACK.
- R10: A STOP that ends a write which stored data, or that ends a lock command, starts a programming interval of `PROG_CYCLES` clocks. During the interval every device byte gets NACK. After it, device bytes get ACK again.
- R11: The slave drives SDA only in its ACK slot and while sending read data. It changes `sdaOe` only while SCL is low, and it releases SDA after STOP and after a master NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level, as resolved on the bus |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain drive) |
| strapAddr | input | 3 | Low three bits of the slave address |
| writeCtrl | input | 1 | 1 blocks all array writes |

## Verification
The bench runs a byte write and a 17-byte page write, which shows whether the address wraps inside the page or carries into the upper bits. It runs a random read and a sequential read that starts at FEh, which shows whether the address wraps at the top and whether the slave releases the line after the master NACKs. A read without a dummy write then shows that the current address was kept. Writes with the inhibit pin set, and writes to both halves after the lock, show which gate rejects the data byte. An ACK poll sent straight after a write, a repeated lock command and a device byte with the wrong strap bits each show that device bytes are declined for the right reason.

// File: rtl/lhe_pkg.sv
package lhe_pkg;

  localparam logic [3:0] MEM_CODE  = 4'b1010;
  localparam logic [3:0] LOCK_CODE = 4'b0110;

  typedef struct packed {
    logic shiftIn;
    logic loadAddr;
    logic writeByte;
    logic loadTx;
    logic shiftTx;
    logic startProg;
    logic setLock;
  } lheStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACKOUT, ST_TX, ST_ACKIN
  } lheState_t;

  typedef enum logic [2:0] {
    K_DEV, K_WADDR, K_WDATA, K_LADDR, K_LDATA
  } lheKind_t;

endpackage

// File: rtl/lhe_busio.sv
module lhe_busio #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLevel,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [SYNC_STAGES-1:0] sclSync;
  logic [SYNC_STAGES-1:0] sdaSync;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclSync[SYNC_STAGES-1];
      sdaPrev <= sdaSync[SYNC_STAGES-1];
    end
  end

  assign sclLevel = sclSync[SYNC_STAGES-1];
  assign sdaLevel = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclLevel & ~sclPrev;
  assign sclFall  = ~sclLevel & sclPrev;
  assign startDet = sclLevel & sclPrev & sdaPrev & ~sdaLevel;
  assign stopDet  = sclLevel & sclPrev & ~sdaPrev & sdaLevel;

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(startDet && stopDet) && !(sclRise && sclFall)); // R11

endmodule

// File: rtl/lhe_datapath.sv
module lhe_datapath
  import lhe_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int PROG_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  lheStrobe_t stb,
  input  logic       sdaLevel,
  input  logic       writeCtrl,
  output logic [7:0] rxByte,
  output logic       txMsb,
  output logic       busy,
  output logic       locked,
  output logic       addrMsb
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD = CNT_W'(PROG_CYCLES);

  logic [7:0]        memArr [DEPTH];
  logic [ADDR_W-1:0] curAddr;
  logic [7:0]        rxReg;
  logic [7:0]        txReg;
  logic [CNT_W-1:0]  progCnt;
  logic              lockFlag;
  logic [ADDR_W-1:0] pageNext;

  assign pageNext = {curAddr[ADDR_W-1:PAGE_W], curAddr[PAGE_W-1:0] + 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= 8'hFF;
    end else if (stb.writeByte) begin
      memArr[curAddr] <= rxReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      rxReg    <= '0;
      txReg    <= 8'hFF;
      progCnt  <= '0;
      lockFlag <= 1'b0;
    end else begin
      if (stb.shiftIn) rxReg <= {rxReg[6:0], sdaLevel};
      if (stb.loadAddr) begin
        curAddr <= rxReg[ADDR_W-1:0];
      end else if (stb.writeByte) begin
        curAddr <= pageNext;
      end else if (stb.loadTx) begin
        curAddr <= curAddr + 1'b1;
      end
      if (stb.loadTx) begin
        txReg <= memArr[curAddr];
      end else if (stb.shiftTx) begin
        txReg <= {txReg[6:0], 1'b1};
      end
      if (stb.startProg) begin
        progCnt <= PROG_LOAD;
      end else if (progCnt != '0) begin
        progCnt <= progCnt - 1'b1;
      end
      if (stb.setLock) lockFlag <= 1'b1;
    end
  end

  assign rxByte  = rxReg;
  assign txMsb   = txReg[7];
  assign busy    = (progCnt != '0);
  assign locked  = lockFlag;
  assign addrMsb = curAddr[ADDR_W-1];

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked); // R9
  AST_NO_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeByte |-> !(lockFlag && !curAddr[ADDR_W-1])); // R8
  AST_WC_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeByte |-> !writeCtrl); // R7
  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeByte |=> curAddr[ADDR_W-1:PAGE_W] == $past(curAddr[ADDR_W-1:PAGE_W])); // R4
  AST_READ_INC: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTx |=> curAddr == $past(curAddr) + 1'b1); // R5
  AST_PROG_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.startProg |-> !busy); // R10

endmodule

// File: rtl/lhe_ctrl.sv
module lhe_ctrl
  import lhe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclLevel,
  input  logic       sdaLevel,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [2:0] strapAddr,
  input  logic       writeCtrl,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  input  logic       busy,
  input  logic       locked,
  input  logic       addrMsb,
  output lheStrobe_t stb,
  output logic       sdaOe
);

  lheState_t state;
  lheKind_t  kind;
  lheKind_t  evalKind;
  logic [3:0] bitCnt;
  logic ackDrive, isRead, masterAck, wrPending, lockArmed;
  logic evalNow, evalAck, evalRead, memSel, lockSel, busEvent;

  assign busEvent = startDet | stopDet;
  assign evalNow  = (state == ST_RX) && sclFall && (bitCnt == 4'd8) && !busEvent;
  assign memSel   = (rxByte[7:4] == MEM_CODE) && (rxByte[3:1] == strapAddr);
  assign lockSel  = (rxByte[7:4] == LOCK_CODE) && (rxByte[3:1] == strapAddr) && !rxByte[0];

  always_comb begin
    evalAck  = 1'b1;
    evalKind = kind;
    evalRead = 1'b0;
    unique case (kind)
      K_DEV: begin
        evalAck  = !busy && (memSel || (lockSel && !locked));
        evalRead = memSel && rxByte[0];
        evalKind = lockSel ? K_LADDR : K_WADDR;
      end
      K_WADDR: evalKind = K_WDATA;
      K_WDATA: evalAck  = !writeCtrl && !(locked && !addrMsb);
      K_LADDR: evalKind = K_LDATA;
      K_LDATA: evalAck  = !writeCtrl;
      default: evalAck  = 1'b0;
    endcase
  end

  always_comb begin
    stb = '0;
    stb.shiftIn   = (state == ST_RX) && sclRise && (bitCnt < 4'd8) && !busEvent;
    stb.loadAddr  = evalNow && (kind == K_WADDR);
    stb.writeByte = evalNow && (kind == K_WDATA) && evalAck;
    stb.loadTx    = sclFall && !busEvent &&
                    (((state == ST_ACKOUT) && ackDrive && isRead) ||
                     ((state == ST_ACKIN) && masterAck));
    stb.shiftTx   = (state == ST_TX) && sclFall && (bitCnt != 4'd7) && !busEvent;
    stb.startProg = stopDet && (wrPending || lockArmed);
    stb.setLock   = stopDet && lockArmed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= K_DEV;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      wrPending <= 1'b0;
      lockArmed <= 1'b0;
    end else if (startDet) begin
      state     <= ST_RX;
      kind      <= K_DEV;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      isRead    <= 1'b0;
      lockArmed <= 1'b0;
    end else if (stopDet) begin
      state     <= ST_IDLE;
      ackDrive  <= 1'b0;
      wrPending <= 1'b0;
      lockArmed <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_RX: begin
          if (stb.shiftIn) bitCnt <= bitCnt + 1'b1;
          if (evalNow) begin
            state    <= ST_ACKOUT;
            ackDrive <= evalAck;
            kind     <= evalKind;
            if (kind == K_DEV) isRead <= evalRead;
            if (stb.writeByte) wrPending <= 1'b1;
            if ((kind == K_LDATA) && evalAck) lockArmed <= 1'b1;
          end
        end
        ST_ACKOUT: if (sclFall) begin
          bitCnt   <= '0;
          ackDrive <= 1'b0;
          if (!ackDrive)   state <= ST_IDLE;
          else if (isRead) state <= ST_TX;
          else             state <= ST_RX;
        end
        ST_TX: if (sclFall) begin
          if (bitCnt == 4'd7) state <= ST_ACKIN;
          else                bitCnt <= bitCnt + 1'b1;
        end
        ST_ACKIN: begin
          if (sclRise) masterAck <= !sdaLevel;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= masterAck ? ST_TX : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdaOe = ((state == ST_ACKOUT) && ackDrive) || ((state == ST_TX) && !txMsb);

  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rstN)
    (evalNow && (kind == K_DEV) && busy) |=> (state == ST_ACKOUT) && !ackDrive); // R10
  AST_LOCK_CODE_NACK: assert property (@(posedge clk) disable iff (!rstN)
    (evalNow && (kind == K_DEV) && locked && (rxByte[7:4] == LOCK_CODE)) |=> !ackDrive); // R9
  AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclLevel && $past(sclLevel) && !busEvent) |-> $stable(sdaOe)); // R11
  AST_RELEASE_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe); // R11

endmodule

// File: rtl/lockhalf_eeprom.sv
module lockhalf_eeprom
  import lhe_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int PROG_CYCLES = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic [2:0] strapAddr,
  input  logic       writeCtrl
);

  logic sclLevel, sdaLevel, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxByte;
  logic txMsb, busy, locked, addrMsb;
  lheStrobe_t stb;

  lhe_busio #(.SYNC_STAGES(SYNC_STAGES)) u_busio (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  lhe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .sdaLevel(sdaLevel),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .strapAddr(strapAddr), .writeCtrl(writeCtrl),
    .rxByte(rxByte), .txMsb(txMsb), .busy(busy), .locked(locked),
    .addrMsb(addrMsb), .stb(stb), .sdaOe(sdaOe)
  );

  lhe_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaLevel(sdaLevel),
    .writeCtrl(writeCtrl), .rxByte(rxByte), .txMsb(txMsb), .busy(busy),
    .locked(locked), .addrMsb(addrMsb)
  );

endmodule

// File: tb/lockhalf_eeprom_bench.sv
module lockhalf_eeprom_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PROG = 400;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};
  localparam logic [7:0] LOCK_W = {4'b0110, STRAP, 1'b0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic wc = 1'b0;
  logic sdaOe;
  logic sdaBus;
  assign sdaBus = mSda & ~sdaOe;

  int mMem [256];
  int mAddr = 0;
  bit mLock = 0;
  bit mBusy = 0;
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockhalf_eeprom #(.PROG_CYCLES(PROG)) u_lockhalf_eeprom (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .strapAddr(STRAP), .writeCtrl(wc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic putBit(input bit b);
    waitClk(3); mSda = b;
    waitClk(9); scl = 1'b1;
    waitClk(12); scl = 1'b0;
  endtask

  task automatic getBit(output bit b);
    waitClk(3); mSda = 1'b1;
    waitClk(9); scl = 1'b1;
    waitClk(6); b = sdaBus;
    waitClk(6); scl = 1'b0;
  endtask

  task automatic busStart();
    waitClk(3); mSda = 1'b1;
    waitClk(6); scl = 1'b1;
    waitClk(6); mSda = 1'b0;
    waitClk(6); scl = 1'b0;
  endtask

  task automatic busStop(input string req);
    waitClk(3); mSda = 1'b0;
    waitClk(6); scl = 1'b1;
    waitClk(6); mSda = 1'b1;
    waitClk(6);
    chk(sdaOe == 1'b0, req, sdaOe, 0);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string req);
    bit a;
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    getBit(a);
    chk((!a) == expAck, req, !a, expAck);
  endtask

  task automatic readByte(input int exp, input bit ackIt, input string req);
    logic [7:0] got;
    bit b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      got[i] = b;
    end
    chk(got == exp[7:0], req, got, exp);
    putBit(!ackIt);
  endtask

  task automatic doWrite(input int addr, input int dataQ[$], input string req);
    bit pend = 0;
    bit ok;
    busStart();
    sendByte(DEV_W, !mBusy, req);
    if (mBusy) begin busStop("R11"); return; end
    sendByte(addr[7:0], 1'b1, req);
    mAddr = addr;
    foreach (dataQ[i]) begin
      ok = !wc && !(mLock && mAddr < 128);
      sendByte(dataQ[i][7:0], ok, req);
      if (!ok) break;
      mMem[mAddr] = dataQ[i];
      mAddr = (mAddr & 8'hF0) | ((mAddr + 1) & 8'h0F);
      pend = 1;
    end
    busStop("R11");
    if (pend) mBusy = 1;
  endtask

  task automatic doRead(input bit random, input int addr, input int n, input string req);
    busStart();
    if (random) begin
      sendByte(DEV_W, !mBusy, req);
      sendByte(addr[7:0], 1'b1, req);
      mAddr = addr;
      busStart();
    end
    sendByte(DEV_R, !mBusy, req);
    for (int i = 0; i < n; i++) begin
      readByte(mMem[mAddr], i < n - 1, req);
      mAddr = (mAddr + 1) & 255;
    end
    busStop("R11");
  endtask

  task automatic doLock(input string req);
    bit exp;
    exp = !mBusy && !mLock;
    busStart();
    sendByte(LOCK_W, exp, req);
    if (exp) begin
      sendByte(8'h00, 1'b1, req);
      sendByte(8'h00, !wc, req);
    end
    busStop("R11");
    if (exp && !wc) begin mLock = 1; mBusy = 1; end
  endtask

  task automatic waitProg();
    waitClk(PROG + 40);
    mBusy = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int pageQ[$];
    for (int i = 0; i < 256; i++) mMem[i] = 8'hFF;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    chk(sdaOe == 1'b0, "R1", sdaOe, 0);
    // R1 + R5: current-address read from reset address 00h gives erased value
    doRead(0, 0, 1, "R1");
    // R2: wrong strap bits are declined
    busStart();
    sendByte({4'b1010, 3'b010, 1'b0}, 1'b0, "R2");
    busStop("R11");
    // R3 + R10: byte write, poll during programming, then read back
    doWrite(8'h10, '{8'h5A}, "R3");
    busStart();
    sendByte(DEV_W, 1'b0, "R10");
    busStop("R11");
    waitProg();
    doRead(1, 8'h10, 1, "R3");
    // R4: 17 bytes from 23h wrap inside page 20h
    for (int i = 0; i < 17; i++) pageQ.push_back(8'h40 + i);
    doWrite(8'h23, pageQ, "R4");
    waitProg();
    doRead(1, 8'h20, 16, "R4");
    // R6: sequential read wraps FFh -> 00h; R5 current-address continues
    doWrite(8'hFE, '{8'h11, 8'h22}, "R6");
    waitProg();
    doRead(1, 8'hFE, 4, "R6");
    doRead(0, 0, 1, "R5");
    // R7: write inhibit
    wc = 1'b1;
    doWrite(8'h90, '{8'h77}, "R7");
    wc = 1'b0;
    doRead(1, 8'h90, 1, "R7");
    // R8: lock, lower half rejected, upper half accepted
    doLock("R8");
    waitProg();
    doWrite(8'h05, '{8'h33}, "R8");
    doWrite(8'h85, '{8'h44}, "R8");
    waitProg();
    doRead(1, 8'h05, 1, "R8");
    doRead(1, 8'h85, 1, "R8");
    // R9: lock code now declined, lock still effective
    doLock("R9");
    doWrite(8'h10, '{8'h99}, "R9");
    doRead(1, 8'h10, 1, "R9");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule